// File: doc/BRIEF.md
# Macroblock Best-Match SAD Search with Transform Skip

This block scores a 16x16 luminance macroblock of the current frame against a series of candidate blocks taken from a reference frame. Every candidate is scored by a sum of absolute differences (SAD): for each pixel, the block takes the magnitude of the current sample minus the co-located candidate sample and adds it to a running total. The block keeps the candidate with the smallest total, together with the horizontal and vertical displacement that the source attached to it.

After the last candidate, the block compares the winning SAD with a programmable energy threshold. When the residual is small enough, it raises a skip flag that tells the downstream transform stage to leave the whole macroblock out of transform work. The source supplies pixel pairs one per cycle on a valid/ready stream. A start marker opens each candidate, an end marker closes it, and a separate flag on the closing beat marks the final candidate of the search.

The controller has three states. SEARCH_IDLE waits for a start-marked beat; this is also the only state in which the threshold can be written. SEARCH_RUN accumulates candidates. SEARCH_REPORT presents the result for one cycle. The transitions are:
- start_search: SEARCH_IDLE to SEARCH_RUN, taken on an accepted start-marked beat.
- finish_search: SEARCH_RUN to SEARCH_REPORT, or directly from SEARCH_IDLE when a one-beat final candidate arrives, taken on the end-marked beat of the final candidate.
- rearm: SEARCH_REPORT to SEARCH_IDLE, taken unconditionally after one cycle.

Top module: `mb_sad_skip`

## Requirements
- R1: Pixels are 8-bit unsigned. A candidate's SAD is the sum of |cur_pix - ref_pix| over every accepted beat from its start-marked beat (`cand_first`=1) through its end-marked beat (`cand_last`=1). The sum is held in 16 bits with no wrap, so a 256-beat candidate with cur=255 and ref=0 scores 65280.
- R2: The reported best SAD is the smallest candidate SAD of the search. The reported displacement is the `cand_dx`/`cand_dy` value presented on that candidate's start-marked beat.
- R3: When a later candidate's SAD equals the current best, the earlier candidate and its displacement are kept.
- R4: `done` is high for exactly one cycle: the cycle after the accepted end-marked beat that carries `search_last`=1. `in_ready` is low during that cycle and high in every other state.
- R5: `skip` is 1 while `done` is 1 only when best SAD < threshold, using a strict comparison. A best SAD equal to the threshold gives `skip`=0. Outside `done`, `skip` is 0.
- R6: A `thr_load` pulse writes `thr_value` into the threshold only while the block is in SEARCH_IDLE. A pulse during SEARCH_RUN or SEARCH_REPORT has no effect on the threshold.
- R7: After reset, `done`=0, `skip`=0, `in_ready`=1, the threshold is 0 and the best-so-far register holds its all-ones maximum. The best-so-far register returns to that maximum after every report, so searches do not affect one another.
- R8: A beat accepted in SEARCH_IDLE without the start marker is discarded. It contributes to no SAD and starts no search, even if it carries the end and final-candidate markers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| thr_load | input | 1 | Threshold write strobe (honoured in SEARCH_IDLE only) |
| thr_value | input | 16 | Threshold value to write |
| in_valid | input | 1 | Pixel pair valid |
| in_ready | output | 1 | Block accepts a pixel pair this cycle |
| cur_pix | input | 8 | Current macroblock luminance sample |
| ref_pix | input | 8 | Co-located candidate luminance sample |
| cand_first | input | 1 | Marks the first beat of a candidate |
| cand_last | input | 1 | Marks the last beat of a candidate |
| search_last | input | 1 | On an end-marked beat, marks the final candidate |
| cand_dx | input | 6 | Signed horizontal displacement, taken on the start-marked beat |
| cand_dy | input | 6 | Signed vertical displacement, taken on the start-marked beat |
| done | output | 1 | One-cycle result strobe |
| best_sad | output | 16 | Lowest SAD of the search, valid with done |
| best_dx | output | 6 | Displacement x of the winner, valid with done |
| best_dy | output | 6 | Displacement y of the winner, valid with done |
| skip | output | 1 | Transform skip decision, valid with done |

## Verification
A corrupted accumulator or a missed restart at a start marker changes `best_sad` in the very next report, and that report arrives one cycle after the final beat. A best-so-far register that is not re-armed after a report leaks into the following search. It shows up as too small a SAD, or a stale displacement, in the next `done` cycle. A controller stuck in the wrong state shows up at the ports as a missing, doubled or early `done`, or as `in_ready` held low. A threshold written outside SEARCH_IDLE flips `skip` at the next report.

// File: rtl/mb_sad_pkg.sv
package mb_sad_pkg;
    typedef enum logic [1:0] {
        SEARCH_IDLE   = 2'd0,
        SEARCH_RUN    = 2'd1,
        SEARCH_REPORT = 2'd2
    } search_state_e;
endpackage

// File: rtl/sad_absdiff.sv
module sad_absdiff #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a_pix,
    input  logic [PIX_W-1:0] b_pix,
    output logic [PIX_W-1:0] mag
);
    always_comb begin
        if (a_pix >= b_pix) mag = a_pix - b_pix;
        else                mag = b_pix - a_pix;
    end
endmodule

// File: rtl/sad_accum.sv
module sad_accum #(
    parameter int PIX_W = 8,
    parameter int SAD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             restart,
    input  logic [PIX_W-1:0] term,
    output logic [SAD_W-1:0] sum_now
);
    logic [SAD_W-1:0] acc_q;
    logic [SAD_W:0]   sum_wide;

    always_comb begin
        sum_wide = {1'b0, (restart ? {SAD_W{1'b0}} : acc_q)}
                 + {{(SAD_W+1-PIX_W){1'b0}}, term};
        sum_now  = sum_wide[SAD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)       acc_q <= '0;
        else if (step) acc_q <= sum_now;
    end

    // R1: the running total never wraps
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        step |-> !sum_wide[SAD_W]);
endmodule

// File: rtl/sad_best_track.sv
module sad_best_track #(
    parameter int SAD_W  = 16,
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rearm,
    input  logic              cand_done,
    input  logic [SAD_W-1:0]  cand_sad,
    input  logic [DISP_W-1:0] cand_dx,
    input  logic [DISP_W-1:0] cand_dy,
    output logic [SAD_W-1:0]  best_sad,
    output logic [DISP_W-1:0] best_dx,
    output logic [DISP_W-1:0] best_dy
);
    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            best_sad <= {SAD_W{1'b1}};
            best_dx  <= '0;
            best_dy  <= '0;
        end else if (cand_done && (cand_sad < best_sad)) begin
            best_sad <= cand_sad;
            best_dx  <= cand_dx;
            best_dy  <= cand_dy;
        end
    end

    // R2/R3: within a search the best value only moves down
    assert_best_never_rises_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(rearm) |-> best_sad <= $past(best_sad));
endmodule

// File: rtl/mb_sad_skip.sv
module mb_sad_skip
    import mb_sad_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int MB_SIDE = 16,
    parameter int DISP_W  = 6,
    localparam int SAMPLES = MB_SIDE * MB_SIDE,
    localparam int SAD_W   = $clog2(SAMPLES * ((1 << PIX_W) - 1) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              thr_load,
    input  logic [SAD_W-1:0]  thr_value,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  cur_pix,
    input  logic [PIX_W-1:0]  ref_pix,
    input  logic              cand_first,
    input  logic              cand_last,
    input  logic              search_last,
    input  logic [DISP_W-1:0] cand_dx,
    input  logic [DISP_W-1:0] cand_dy,
    output logic              done,
    output logic [SAD_W-1:0]  best_sad,
    output logic [DISP_W-1:0] best_dx,
    output logic [DISP_W-1:0] best_dy,
    output logic              skip
);
    search_state_e     state_q, state_d;
    logic              accept, step, cand_done, finish;
    logic [PIX_W-1:0]  term;
    logic [SAD_W-1:0]  cand_sad;
    logic [SAD_W-1:0]  thresh_q;
    logic [DISP_W-1:0] dx_q, dy_q, dx_use, dy_use;

    assign accept    = in_valid && in_ready;
    assign step      = accept && ((state_q == SEARCH_RUN) ||
                                  (state_q == SEARCH_IDLE && cand_first));
    assign cand_done = step && cand_last;
    assign finish    = cand_done && search_last;
    assign dx_use    = cand_first ? cand_dx : dx_q;
    assign dy_use    = cand_first ? cand_dy : dy_q;

    sad_absdiff #(.PIX_W(PIX_W)) u_absdiff (
        .a_pix (cur_pix),
        .b_pix (ref_pix),
        .mag   (term)
    );

    sad_accum #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_accum (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .restart (cand_first),
        .term    (term),
        .sum_now (cand_sad)
    );

    sad_best_track #(.SAD_W(SAD_W), .DISP_W(DISP_W)) u_best (
        .clk       (clk),
        .rst       (rst),
        .rearm     (state_q == SEARCH_REPORT),
        .cand_done (cand_done),
        .cand_sad  (cand_sad),
        .cand_dx   (dx_use),
        .cand_dy   (dy_use),
        .best_sad  (best_sad),
        .best_dx   (best_dx),
        .best_dy   (best_dy)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEARCH_IDLE:   if (step) state_d = finish ? SEARCH_REPORT : SEARCH_RUN;
            SEARCH_RUN:    if (finish) state_d = SEARCH_REPORT;
            SEARCH_REPORT: state_d = SEARCH_IDLE;
            default:       state_d = SEARCH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SEARCH_IDLE;
        else     state_q <= state_d;
    end

    // datapath registers: displacement capture and threshold
    always_ff @(posedge clk) begin
        if (rst) begin
            dx_q     <= '0;
            dy_q     <= '0;
            thresh_q <= '0;
        end else begin
            if (step && cand_first) begin
                dx_q <= cand_dx;
                dy_q <= cand_dy;
            end
            if (thr_load && state_q == SEARCH_IDLE) thresh_q <= thr_value;
        end
    end

    // outputs
    always_comb begin
        in_ready = 1'b1;
        done     = 1'b0;
        skip     = 1'b0;
        unique case (state_q)
            SEARCH_IDLE, SEARCH_RUN: in_ready = 1'b1;
            SEARCH_REPORT: begin
                in_ready = 1'b0;
                done     = 1'b1;
                skip     = best_sad < thresh_q;
            end
            default: in_ready = 1'b1;
        endcase
    end

    assert_done_after_final_R4: assert property (@(posedge clk) disable iff (rst)
        finish |=> done);
    assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_thresh_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q != SEARCH_IDLE) |=> $stable(thresh_q));
    assert_best_rearmed_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> best_sad == {SAD_W{1'b1}});
    assert_stray_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == SEARCH_IDLE && accept && !cand_first) |=> state_q == SEARCH_IDLE);
endmodule

// File: tb/mb_sad_skip_bench.sv
`timescale 1ns/1ps
module mb_sad_skip_bench;
    typedef struct {
        int sad;
        int dx;
        int dy;
        bit skp;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic thr_load = 1'b0;
    logic [15:0] thr_value = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] cur_pix = '0, ref_pix = '0;
    logic cand_first = 1'b0, cand_last = 1'b0, search_last = 1'b0;
    logic [5:0] cand_dx = '0, cand_dy = '0;
    logic done, skip;
    logic [15:0] best_sad;
    logic [5:0] best_dx, best_dy;

    int checks = 0, fails = 0;
    int exp_thr = 0;
    exp_t exp_q[$];
    bit prev_done = 1'b0;

    int c_mode[8], c_d[8], c_k[8], c_dx[8], c_dy[8];

    always #2.5 clk = ~clk;

    mb_sad_skip u_mb_sad_skip (
        .clk(clk), .rst(rst), .thr_load(thr_load), .thr_value(thr_value),
        .in_valid(in_valid), .in_ready(in_ready), .cur_pix(cur_pix), .ref_pix(ref_pix),
        .cand_first(cand_first), .cand_last(cand_last), .search_last(search_last),
        .cand_dx(cand_dx), .cand_dy(cand_dy), .done(done), .best_sad(best_sad),
        .best_dx(best_dx), .best_dy(best_dy), .skip(skip)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_beat(input int c, input int r, input bit f, input bit l,
                             input bit sl, input int dx, input int dy);
        @(negedge clk);
        in_valid = 1'b1; cur_pix = c[7:0]; ref_pix = r[7:0];
        cand_first = f; cand_last = l; search_last = sl;
        cand_dx = dx[5:0]; cand_dy = dy[5:0];
        while (!in_ready) @(negedge clk);
    endtask

    task automatic idle_cycles(input int n);
        @(negedge clk);
        in_valid = 1'b0; cand_first = 1'b0; cand_last = 1'b0; search_last = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
    endtask

    task automatic load_thr(input int v, input bit is_idle);
        @(negedge clk);
        in_valid = 1'b0;
        thr_load = 1'b1; thr_value = v[15:0];
        if (is_idle) exp_thr = v;
        @(negedge clk);
        thr_load = 1'b0;
    endtask

    // mode 0: cur varies, ref = cur + d + (i*k)%3 ; mode 1: cur=255 ref=0
    task automatic send_cand(input int idx, input bit fin, input bit thr_poke, output int sad);
        sad = 0;
        for (int i = 0; i < 256; i++) begin
            int c, r, a;
            if (c_mode[idx] == 1) begin c = 255; r = 0; end
            else begin
                c = 20 + ((i * 37) % 200);
                r = c + c_d[idx] + ((i * c_k[idx]) % 3);
            end
            a = (c > r) ? c - r : r - c;
            sad += a;
            send_beat(c, r, i == 0, i == 255, fin && i == 255, c_dx[idx], c_dy[idx]);
            if (thr_poke && i == 100) begin
                load_thr(0, 1'b0);
            end
        end
    endtask

    task automatic run_search(input int n, input bit thr_poke, input string tag);
        exp_t e;
        int best = 65535, bdx = 0, bdy = 0;
        for (int j = 0; j < n; j++) begin
            int s;
            send_cand(j, j == n - 1, thr_poke && j == 1, s);
            if (s < best) begin best = s; bdx = c_dx[j]; bdy = c_dy[j]; end
        end
        e.sad = best; e.dx = bdx & 63; e.dy = bdy & 63;
        e.skp = best < exp_thr; e.tag = tag;
        exp_q.push_back(e);
        idle_cycles(3);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                check(!in_ready, "R4 ready low in report", in_ready, 0);
                check(!prev_done, "R4 single-cycle done", prev_done, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(best_sad == e.sad[15:0], {e.tag, " best_sad"}, best_sad, e.sad);
                    check(best_dx == e.dx[5:0], {e.tag, " best_dx"}, best_dx, e.dx);
                    check(best_dy == e.dy[5:0], {e.tag, " best_dy"}, best_dy, e.dy);
                    check(skip == e.skp, {e.tag, " skip"}, skip, e.skp);
                end
            end else begin
                if (skip) check(1'b0, "R5 skip outside done", 1, 0);
            end
            prev_done = done;
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(done == 1'b0, "R7 done after reset", done, 0);
        check(skip == 1'b0, "R7 skip after reset", skip, 0);
        check(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);

        // R1 R2: four varied candidates, threshold 600
        load_thr(600, 1'b1);
        c_mode = '{0,0,0,0,0,0,0,0};
        c_d  = '{7, 3, 1, 5, 0,0,0,0};
        c_k  = '{1, 2, 1, 0, 0,0,0,0};
        c_dx = '{-3, 4, 2, -1, 0,0,0,0};
        c_dy = '{1, -5, 7, 0, 0,0,0,0};
        run_search(4, 1'b0, "R1 R2 varied");

        // R3: tie between candidates 1 and 3, earlier wins; R5 equal threshold -> no skip
        load_thr(512, 1'b1);
        c_d  = '{5, 2, 9, -2, 0,0,0,0};
        c_k  = '{0, 0, 0, 0, 0,0,0,0};
        c_dx = '{1, 6, -7, 3, 0,0,0,0};
        c_dy = '{2, -2, 5, 9, 0,0,0,0};
        run_search(4, 1'b0, "R3 R5 tie equal-threshold");

        // R5 threshold one above best -> skip
        load_thr(513, 1'b1);
        run_search(4, 1'b0, "R5 threshold above");

        // R1 maximum SAD 65280, threshold 65535 -> skip; R7 rearm makes it independent
        load_thr(65535, 1'b1);
        c_mode = '{1,0,0,0,0,0,0,0};
        c_dx = '{-8, 0,0,0,0,0,0,0};
        c_dy = '{11, 0,0,0,0,0,0,0};
        run_search(1, 1'b0, "R1 R7 max sad");

        // R5 zero SAD with threshold 0 -> no skip
        load_thr(0, 1'b1);
        c_mode = '{0,0,0,0,0,0,0,0};
        c_d  = '{4, 0, 0,0,0,0,0,0};
        c_k  = '{0, 0, 0,0,0,0,0,0};
        c_dx = '{2, -4, 0,0,0,0,0,0};
        c_dy = '{3, 6, 0,0,0,0,0,0};
        run_search(2, 1'b0, "R5 zero sad zero threshold");

        // R8 stray beat in idle with all end markers; R6 threshold poke mid-search ignored
        load_thr(2000, 1'b1);
        send_beat(255, 0, 1'b0, 1'b1, 1'b1, 5, 5);
        idle_cycles(3);
        check(done == 1'b0 && exp_q.size() == 0, "R8 stray beat no report", done, 0);
        c_d  = '{3, 6, 0,0,0,0,0,0};
        c_k  = '{2, 1, 0,0,0,0,0,0};
        c_dx = '{-9, 10, 0,0,0,0,0,0};
        c_dy = '{-1, 12, 0,0,0,0,0,0};
        run_search(2, 1'b1, "R6 R8 stray and poke");

        idle_cycles(4);
        check(exp_q.size() == 0, "R4 all reports seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule